// File: doc/BRIEF.md
# Four-Channel Pulse-Width Modulator with Deferred Commit

This block produces four independent pulse-width modulated outputs. Each output is set up through a small memory-mapped register bus. Every channel has a clock divider, a period counter and a duty comparator. The divider turns the source clock into counter steps. The output is high while the period counter is below the duty value.

Software stages a divider value and a period length first. It then writes the duty value, and that write is the commit. The staged values are pending until the running period finishes, so a period never mixes old and new settings. Clearing a channel's enable bit stops that channel at once, mid-period if need be. Setting the enable bit loads any pending settings at once and starts a fresh period.

The register bus is a plain strobe interface with a byte address and 32-bit data. A write completes in the cycle its strobe is sampled. Read data is registered and appears on the cycle after the read strobe. It holds until the next read.

Top module: `pwm_commit_bank`

## Requirements
- R1: Address bits [6:5] select the channel and bit 7 must be 0, giving a 32-byte stride. Within a channel, offset 0x00 is the divider, 0x04 the period length, 0x08 the duty value and 0x18 the enable bit (bit 0). A write reaches exactly one register of one channel.
- R2: The divider and period length keep the low 8 bits of a written word, and the duty value keeps the low 16 bits. A read returns the staged value, zero-extended, on the cycle after the read strobe.
- R3: After reset every register reads 0, every output is low and the read data is 0.
- R4: With divider P, period length M > 0 and duty D < M, the output repeats every (P+1)·M cycles. It is high for the first (P+1)·D cycles of each period.
- R5: If D ≥ M the output stays high for the whole period. If D = 0 it stays low.
- R6: Writing the divider or the period length alone never changes the output.
- R7: A duty write on a running channel marks the staged settings as pending. They take effect only at the next period boundary, and the new period starts with them.
- R8: Setting enable from the disabled state loads pending settings at once. The first period starts in the cycle that follows the write. Writing 1 to an enabled channel has no effect.
- R9: Writing 0 to enable stops the channel at once. The output is low from the next cycle and the counters restart from zero.
- R10: An active period length of 0 keeps the output low and the counters at zero. A pending commit on such an enabled channel is loaded at once.
- R11: Reads of unmapped addresses return 0. Writes to unmapped addresses change no register and no output.
- R12: Each channel's outputs and registers are unaffected by accesses to any other channel.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Source clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_wr | input | 1 | Write strobe |
| bus_rd | input | 1 | Read strobe |
| bus_addr | input | 8 | Byte address |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Registered read data |
| pwm_out | output | 4 | One modulated output per channel |

## Verification
Every register write takes effect at the rising edge that samples its strobe. The output reflects the write from that edge onward. A stop, a start, or a commit that reaches a period boundary therefore shows on the output in the cycle right after that edge. Read data is due one edge after the read strobe. The bench drives the bus on falling edges and advances a reference model on each rising edge. That model counts elapsed cycles in the period against (P+1)·M and (P+1)·D. At the following falling edge the bench compares all four outputs with the model, and it compares the read data after the edge that registers it.

// File: rtl/pwmc_pkg.sv
package pwmc_pkg;
  localparam int STRIDE_SH = 5;
  localparam logic [STRIDE_SH-1:0] OFS_DIV  = 5'h00;
  localparam logic [STRIDE_SH-1:0] OFS_LEN  = 5'h04;
  localparam logic [STRIDE_SH-1:0] OFS_DUTY = 5'h08;
  localparam logic [STRIDE_SH-1:0] OFS_RUN  = 5'h18;

  typedef enum logic [2:0] {
    FLD_NONE,
    FLD_DIV,
    FLD_LEN,
    FLD_DUTY,
    FLD_RUN
  } fld_e;
endpackage

// File: rtl/pwmc_regdec.sv
module pwmc_regdec
  import pwmc_pkg::*;
#(
  parameter int NCH    = 4,
  parameter int ADDR_W = 8,
  localparam int CH_W  = (NCH > 1) ? $clog2(NCH) : 1
) (
  input  logic [ADDR_W-1:0] addr,
  output logic              hit,
  output logic [CH_W-1:0]   ch,
  output fld_e              fld
);
  logic in_range;
  logic ch_ok;

  assign in_range = (addr[ADDR_W-1:STRIDE_SH+CH_W] == '0);
  assign ch       = addr[STRIDE_SH +: CH_W];
  assign ch_ok    = (int'(ch) < NCH);

  always_comb begin
    unique case (addr[STRIDE_SH-1:0])
      OFS_DIV:  fld = FLD_DIV;
      OFS_LEN:  fld = FLD_LEN;
      OFS_DUTY: fld = FLD_DUTY;
      OFS_RUN:  fld = FLD_RUN;
      default:  fld = FLD_NONE;
    endcase
  end

  assign hit = in_range && ch_ok && (fld != FLD_NONE);
endmodule

// File: rtl/pwmc_timebase.sv
module pwmc_timebase #(
  parameter int PRE_W = 8,
  parameter int MOD_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             clr,
  input  logic             run,
  input  logic [PRE_W-1:0] div,
  input  logic [MOD_W-1:0] len,
  output logic [MOD_W-1:0] cnt,
  output logic             wrap
);
  logic [PRE_W-1:0] pc;
  logic             step;
  logic             last;

  assign step = run && (pc == div);
  assign last = (cnt == len - MOD_W'(1));
  assign wrap = step && last;

  always_ff @(posedge clk) begin
    if (!rst_n || clr) begin
      pc  <= '0;
      cnt <= '0;
    end else if (run) begin
      if (step) begin
        pc  <= '0;
        cnt <= last ? '0 : cnt + MOD_W'(1);
      end else begin
        pc <= pc + PRE_W'(1);
      end
    end
  end

  // R4
  cnt_in_len_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (run && !clr) |=> (cnt < len || $changed(len)));
endmodule

// File: rtl/pwmc_channel.sv
module pwmc_channel #(
  parameter int PRE_W  = 8,
  parameter int MOD_W  = 8,
  parameter int DUTY_W = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              we_div,
  input  logic              we_len,
  input  logic              we_duty,
  input  logic              we_run,
  input  logic [DUTY_W-1:0] wdata,
  output logic [PRE_W-1:0]  rb_div,
  output logic [MOD_W-1:0]  rb_len,
  output logic [DUTY_W-1:0] rb_duty,
  output logic              rb_run,
  output logic              pwm_o
);
  logic [PRE_W-1:0]  stg_div,  act_div;
  logic [MOD_W-1:0]  stg_len,  act_len;
  logic [DUTY_W-1:0] stg_duty, act_duty;
  logic              run_q, pend;
  logic              start, stop, ld, tb_run, wrap;
  logic [MOD_W-1:0]  cnt;

  assign start  = we_run && wdata[0] && !run_q;
  assign stop   = we_run && !wdata[0];
  assign tb_run = run_q && (act_len != '0);
  assign ld     = pend && (start ||
                  (run_q && !stop && ((act_len == '0) || wrap)));

  pwmc_timebase #(.PRE_W(PRE_W), .MOD_W(MOD_W)) tb_i (
    .clk  (clk),
    .rst_n(rst_n),
    .clr  (start || stop),
    .run  (tb_run),
    .div  (act_div),
    .len  (act_len),
    .cnt  (cnt),
    .wrap (wrap)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      stg_div  <= '0;
      stg_len  <= '0;
      stg_duty <= '0;
      act_div  <= '0;
      act_len  <= '0;
      act_duty <= '0;
      run_q    <= 1'b0;
      pend     <= 1'b0;
    end else begin
      if (ld) begin
        act_div  <= stg_div;
        act_len  <= stg_len;
        act_duty <= stg_duty;
      end
      if (we_div)  stg_div  <= wdata[PRE_W-1:0];
      if (we_len)  stg_len  <= wdata[MOD_W-1:0];
      if (we_duty) stg_duty <= wdata;
      if (start)      run_q <= 1'b1;
      else if (stop)  run_q <= 1'b0;
      if (we_duty)    pend <= 1'b1;
      else if (ld)    pend <= 1'b0;
    end
  end

  assign pwm_o   = run_q && (act_len != '0) && (DUTY_W'(cnt) < act_duty);
  assign rb_div  = stg_div;
  assign rb_len  = stg_len;
  assign rb_duty = stg_duty;
  assign rb_run  = run_q;

  // R9
  stop_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
    stop |=> !pwm_o);

  // R7
  act_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !ld |=> ($stable(act_div) && $stable(act_len) && $stable(act_duty)));

  // R10
  idle_len_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (act_len == '0) |-> (cnt == '0 && !pwm_o));
endmodule

// File: rtl/pwm_commit_bank.sv
module pwm_commit_bank
  import pwmc_pkg::*;
#(
  parameter int NCH    = 4,
  parameter int ADDR_W = 8,
  parameter int DATA_W = 32,
  parameter int PRE_W  = 8,
  parameter int MOD_W  = 8,
  parameter int DUTY_W = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bus_wr,
  input  logic              bus_rd,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [DATA_W-1:0] bus_wdata,
  output logic [DATA_W-1:0] bus_rdata,
  output logic [NCH-1:0]    pwm_out
);
  localparam int CH_W = (NCH > 1) ? $clog2(NCH) : 1;

  logic            hit;
  logic [CH_W-1:0] ch;
  fld_e            fld;
  logic [NCH-1:0]  wr_sel;
  logic [DATA_W-1:0] w_div [NCH];
  logic [DATA_W-1:0] w_len [NCH];
  logic [DATA_W-1:0] w_duty[NCH];
  logic [DATA_W-1:0] w_run [NCH];
  logic [DATA_W-1:0] rd_val;
  logic              unused_hi;

  assign unused_hi = ^bus_wdata[DATA_W-1:DUTY_W];

  pwmc_regdec #(.NCH(NCH), .ADDR_W(ADDR_W)) dec_i (
    .addr(bus_addr),
    .hit (hit),
    .ch  (ch),
    .fld (fld)
  );

  for (genvar g = 0; g < NCH; g++) begin : g_ch
    logic [PRE_W-1:0]  rdiv;
    logic [MOD_W-1:0]  rlen;
    logic [DUTY_W-1:0] rduty;
    logic              rrun;

    assign wr_sel[g] = bus_wr && hit && (ch == CH_W'(g));

    pwmc_channel #(.PRE_W(PRE_W), .MOD_W(MOD_W), .DUTY_W(DUTY_W)) ch_i (
      .clk    (clk),
      .rst_n  (rst_n),
      .we_div (wr_sel[g] && fld == FLD_DIV),
      .we_len (wr_sel[g] && fld == FLD_LEN),
      .we_duty(wr_sel[g] && fld == FLD_DUTY),
      .we_run (wr_sel[g] && fld == FLD_RUN),
      .wdata  (bus_wdata[DUTY_W-1:0]),
      .rb_div (rdiv),
      .rb_len (rlen),
      .rb_duty(rduty),
      .rb_run (rrun),
      .pwm_o  (pwm_out[g])
    );

    assign w_div[g]  = DATA_W'(rdiv);
    assign w_len[g]  = DATA_W'(rlen);
    assign w_duty[g] = DATA_W'(rduty);
    assign w_run[g]  = DATA_W'(rrun);
  end

  always_comb begin
    rd_val = '0;
    if (hit) begin
      unique case (fld)
        FLD_DIV:  rd_val = w_div[ch];
        FLD_LEN:  rd_val = w_len[ch];
        FLD_DUTY: rd_val = w_duty[ch];
        FLD_RUN:  rd_val = w_run[ch];
        default:  rd_val = '0;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n)      bus_rdata <= '0;
    else if (bus_rd) bus_rdata <= rd_val;
  end

  // R1
  one_target_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(wr_sel));

  // R11
  unmapped_rd_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_rd && !hit) |=> (bus_rdata == '0));
endmodule

// File: tb/pwm_commit_bank_tb_top.sv
module pwm_commit_bank_tb_top;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        bus_wr = 1'b0, bus_rd = 1'b0;
  logic [7:0]  bus_addr = '0;
  logic [31:0] bus_wdata = '0;
  logic [31:0] bus_rdata;
  logic [3:0]  pwm_out;

  int checks = 0, errors = 0;
  string cur_tag = "R3";

  always #10 clk = ~clk;

  pwm_commit_bank dut_i (
    .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_rd(bus_rd),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata),
    .bus_rdata(bus_rdata), .pwm_out(pwm_out)
  );

  // reference model
  int sp[4], sm[4], sd[4], ap[4], am[4], ad[4], t[4];
  bit en[4], pend[4];

  function automatic bit m_out(int c);
    return en[c] && am[c] != 0 && t[c] < (ap[c] + 1) * ad[c];
  endfunction

  always @(posedge clk) begin
    for (int c = 0; c < 4; c++) begin
      if (!rst_n) begin
        sp[c] = 0; sm[c] = 0; sd[c] = 0; ap[c] = 0; am[c] = 0; ad[c] = 0;
        t[c] = 0; en[c] = 0; pend[c] = 0;
      end else begin
        bit ws, ld;
        int off;
        ws  = bus_wr && bus_addr < 8'h80 && int'(bus_addr[6:5]) == c;
        off = int'(bus_addr[4:0]);
        ld  = 0;
        if (ws && off == 'h18 && !bus_wdata[0]) begin
          en[c] = 0; t[c] = 0;
        end else if (ws && off == 'h18 && !en[c]) begin
          en[c] = 1; t[c] = 0; ld = pend[c];
        end else if (en[c]) begin
          if (am[c] == 0) ld = pend[c];
          else if (t[c] + 1 == (ap[c] + 1) * am[c]) begin
            t[c] = 0; ld = pend[c];
          end else t[c]++;
        end
        if (ld) begin ap[c] = sp[c]; am[c] = sm[c]; ad[c] = sd[c]; end
        if (ws && off == 8) pend[c] = 1;
        else if (ld) pend[c] = 0;
        if (ws && off == 0) sp[c] = int'(bus_wdata[7:0]);
        if (ws && off == 4) sm[c] = int'(bus_wdata[7:0]);
        if (ws && off == 8) sd[c] = int'(bus_wdata[15:0]);
      end
    end
  end

  function automatic int exp_rd(logic [7:0] a);
    int c;
    if (a >= 8'h80) return 0;
    c = int'(a[6:5]);
    case (int'(a[4:0]))
      0: return sp[c];
      4: return sm[c];
      8: return sd[c];
      'h18: return int'(en[c]);
      default: return 0;
    endcase
  endfunction

  task automatic chk(bit ok, string tag, int act, int expv);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual %0h expected %0h at %0t", tag, act, expv, $time);
    end
  endtask

  task automatic tick();
    logic [3:0] e;
    @(negedge clk);
    for (int c = 0; c < 4; c++) e[c] = m_out(c);
    chk(pwm_out === e, cur_tag, int'(pwm_out), int'(e));
  endtask

  task automatic wr(logic [7:0] a, logic [31:0] d);
    bus_wr = 1; bus_addr = a; bus_wdata = d;
    tick();
    bus_wr = 0;
  endtask

  task automatic rd(logic [7:0] a, string tag);
    int e;
    bus_rd = 1; bus_addr = a;
    tick();
    bus_rd = 0;
    e = exp_rd(a);
    chk(bus_rdata === 32'(e), tag, int'(bus_rdata), e);
  endtask

  task automatic idle(int n);
    for (int i = 0; i < n; i++) tick();
  endtask

  initial begin
    #(20 * 200000);
    errors++;
    $display("FAIL watchdog: actual hang expected finish");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    void'($urandom(32'd2024));
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    // R3 reset state
    chk(pwm_out === 4'b0 && bus_rdata === 32'b0, "R3", int'(pwm_out), 0);
    rd(8'h00, "R3"); rd(8'h28, "R3"); rd(8'h78, "R3");

    // R4 basic waveform on channel 0
    cur_tag = "R4";
    wr(8'h00, 1); wr(8'h04, 4); wr(8'h08, 2); wr(8'h18, 1);
    idle(30);
    // R8 enable already enabled: no effect
    cur_tag = "R8";
    wr(8'h18, 32'h3); idle(12);
    // R2 truncation and readback
    rd(8'h00, "R1"); rd(8'h18, "R1");
    wr(8'h28, 32'h12345); rd(8'h28, "R2");
    wr(8'h24, 32'h1FF);   rd(8'h24, "R2");
    // R5 duty >= length on channel 1: always high
    cur_tag = "R5";
    wr(8'h20, 0); wr(8'h28, 32'h2345); wr(8'h38, 1); idle(20);
    // R5 duty zero on channel 2
    wr(8'h44, 5); wr(8'h48, 0); wr(8'h58, 1); idle(15);
    // R6 staging without commit leaves output alone
    cur_tag = "R6";
    wr(8'h00, 3); wr(8'h04, 7); idle(25);
    // R7 commit mid-period
    cur_tag = "R7";
    wr(8'h08, 5); idle(40);
    // R9 stop mid-period
    cur_tag = "R9";
    idle(3); wr(8'h18, 0); idle(6);
    // R8 restart loads nothing new; then commit while stopped and start
    cur_tag = "R8";
    wr(8'h04, 3); wr(8'h00, 0); wr(8'h08, 1); idle(4); wr(8'h18, 1); idle(12);
    // R10 zero length
    cur_tag = "R10";
    wr(8'h64, 0); wr(8'h68, 3); wr(8'h78, 1); idle(10);
    wr(8'h64, 2); wr(8'h68, 1); idle(10);
    // R11 unmapped accesses
    cur_tag = "R11";
    wr(8'h0C, 32'hFF); wr(8'h84, 32'hFF); wr(8'h9C, 1); idle(5);
    rd(8'h0C, "R11"); rd(8'h90, "R11"); rd(8'h1C, "R11"); rd(8'h04, "R11");

    // R12 random mixed traffic
    cur_tag = "R12";
    for (int k = 0; k < 1500; k++) begin
      int op, c;
      logic [7:0] a;
      op = $urandom_range(0, 9);
      c  = $urandom_range(0, 3);
      a  = 8'(c * 32);
      case (op)
        0: wr(a + 8'h00, $urandom_range(0, 3));
        1: wr(a + 8'h04, $urandom_range(0, 8));
        2: wr(a + 8'h08, $urandom_range(0, 10));
        3: wr(a + 8'h18, $urandom_range(0, 1));
        4: rd(a + 8'(4 * $urandom_range(0, 7)), "R12");
        default: idle($urandom_range(1, 20));
      endcase
    end

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule